// File: doc/BRIEF.md
# LCD Line Scan Counter

This block drives the vertical refresh of a 32-row by 80-column bit-per-pixel display memory. It keeps a 5-bit line counter that selects the memory row being shifted out to the segment drivers. Either transition of the frame signal loads the counter from the start line input. Each rising edge of the line clock then moves it one row further, and it wraps from 31 to 0. Changing the start line between frames therefore scrolls the picture vertically by whole rows.

Next to the counter, the block produces a one-hot common select that tracks the line position within the frame. The frame length is 32 or 16 lines. Once that many lines have gone by, the counter returns to the start line by itself. The block also maps the fetched row onto the 80 segment outputs, either in column order or mirrored. It blanks the segments when the display is off. It can also drive every common at once (static drive). Static drive combined with display off gives a power-save state in which all outputs idle and the line clock is ignored.

The frame and line clock inputs are levels sampled by the block clock. Edges are detected internally, so each takes effect on the clock edge where the new level is first seen.

Top module: `lcd_line_scan`

## Requirements
- R1: After reset, with static drive off, row_o is 0 and com_o is 32'h1 (common index 0).
- R2: A change of frame_i in either direction loads row_o with start_line_i and sets the common index to 0, on the same clock edge where the new level is first sampled.
- R3: A rising edge of line_clk_i, with no frame edge and not in power save, increments row_o by one modulo 32 (31 goes to 0) and increments the common index by one.
- R4: The frame length is 32 lines when duty_full_i=1 and 16 lines when duty_full_i=0. The line clock edge that would make the common index equal the frame length instead reloads row_o from start_line_i and sets the common index to 0.
- R5: When a frame edge and a line clock rising edge arrive in the same cycle, the reload of R2 wins and no increment happens.
- R6: In scan mode (static_i=0), com_o has exactly one bit set, at bit position equal to the common index.
- R7: With adc_i=1, seg_o[n] equals row_data_i[n]. With adc_i=0, seg_o[n] equals row_data_i[79-n].
- R8: With disp_on_i=0 and static_i=0, seg_o is all zeros while the common scan and the counter keep running.
- R9: With static_i=1 and disp_on_i=1, com_o is all ones and seg_o shows the row data as in R7.
- R10: With static_i=1 and disp_on_i=0 (power save), seg_o and com_o are all zeros and line clock edges leave row_o unchanged.
- R11: A change of start_line_i without a frame edge or a duty wrap does not alter row_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame signal; both edges mark a frame start |
| line_clk_i | input | 1 | Line clock; rising edge advances one line |
| start_line_i | input | 5 | Memory row shown on the first common |
| duty_full_i | input | 1 | 1: 32-line frame, 0: 16-line frame |
| adc_i | input | 1 | 1: segment n shows column n, 0: mirrored |
| disp_on_i | input | 1 | Display enable |
| static_i | input | 1 | Static drive: all commons selected |
| row_data_i | input | 80 | Contents of the memory row selected by row_o |
| row_o | output | 5 | Memory row pointer for refresh |
| com_o | output | 32 | Common selects |
| seg_o | output | 80 | Segment data |

## Verification
The frame edge reload and the line clock increment can fall in the same clock cycle. The bench provokes this by toggling frame_i and raising line_clk_i at the same falling clock edge while the counter sits away from the start line. The result passes only if row_o equals the start line and com_o selects common 0; a result of start line plus one would show the increment leaking through. A second pairing is also covered. A reload with the duty wrap pending on the same edge is checked by letting the wrap edge coincide with a start line change, and the wrap must fetch the new start line.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  parameter int unsigned LCD_ROWS = 32;
  parameter int unsigned LCD_COLS = 80;

  typedef enum logic [1:0] {
    DRV_SCAN   = 2'd0,
    DRV_BLANK  = 2'd1,
    DRV_STATIC = 2'd2,
    DRV_SAVE   = 2'd3
  } drv_mode_e;
endpackage

// File: rtl/lcd_edge_det.sv
module lcd_edge_det #(
  parameter bit BOTH_EDGES = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  generate
    if (BOTH_EDGES) begin : g_both
      assign edge_o = sig_i ^ sig_q;
    end else begin : g_rise
      assign edge_o = sig_i & ~sig_q;
    end
  endgenerate
endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             step_i,
  input  logic             duty_full_i,
  input  logic [ROW_W-1:0] start_i,
  output logic [ROW_W-1:0] row_o,
  output logic [ROW_W-1:0] idx_o
);
  localparam logic [ROW_W:0] DUTY_HI = (ROW_W+1)'(ROWS);
  localparam logic [ROW_W:0] DUTY_LO = (ROW_W+1)'(ROWS / 2);

  logic [ROW_W-1:0] row_q, idx_q;
  logic [ROW_W:0]   idx_nxt, duty;

  assign duty    = duty_full_i ? DUTY_HI : DUTY_LO;
  assign idx_nxt = {1'b0, idx_q} + 1'b1;

  // frame reload has priority over a line step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      idx_q <= '0;
    end else if (reload_i) begin
      row_q <= start_i;
      idx_q <= '0;
    end else if (step_i) begin
      if (idx_nxt >= duty) begin
        row_q <= start_i;
        idx_q <= '0;
      end else begin
        row_q <= row_q + 1'b1;
        idx_q <= idx_nxt[ROW_W-1:0];
      end
    end
  end

  assign row_o = row_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_scan_pkg::*;
#(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input  drv_mode_e        mode_i,
  input  logic [ROW_W-1:0] idx_i,
  output logic [ROWS-1:0]  com_o
);
  logic [ROWS-1:0] sel;

  for (genvar k = 0; k < ROWS; k++) begin : g_com
    assign sel[k] = (idx_i == ROW_W'(k));
  end

  always_comb begin
    unique case (mode_i)
      DRV_SAVE:   com_o = '0;
      DRV_STATIC: com_o = '1;
      default:    com_o = sel;
    endcase
  end
endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
  import lcd_scan_pkg::*;
#(
  parameter int unsigned COLS = 80
) (
  input  drv_mode_e       mode_i,
  input  logic            adc_i,
  input  logic [COLS-1:0] data_i,
  output logic [COLS-1:0] seg_o
);
  logic blank;
  assign blank = (mode_i == DRV_BLANK) || (mode_i == DRV_SAVE);

  for (genvar n = 0; n < COLS; n++) begin : g_seg
    logic pix;
    assign pix      = adc_i ? data_i[n] : data_i[COLS-1-n];
    assign seg_o[n] = pix & ~blank;
  end
endmodule

// File: rtl/lcd_line_scan.sv
module lcd_line_scan
  import lcd_scan_pkg::*;
#(
  parameter int unsigned ROWS  = LCD_ROWS,
  parameter int unsigned COLS  = LCD_COLS,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             line_clk_i,
  input  logic [ROW_W-1:0] start_line_i,
  input  logic             duty_full_i,
  input  logic             adc_i,
  input  logic             disp_on_i,
  input  logic             static_i,
  input  logic [COLS-1:0]  row_data_i,
  output logic [ROW_W-1:0] row_o,
  output logic [ROWS-1:0]  com_o,
  output logic [COLS-1:0]  seg_o
);
  drv_mode_e        mode;
  logic             fr_edge, cl_rise;
  logic [ROW_W-1:0] idx;

  always_comb begin
    unique case ({static_i, disp_on_i})
      2'b11:   mode = DRV_STATIC;
      2'b10:   mode = DRV_SAVE;
      2'b00:   mode = DRV_BLANK;
      default: mode = DRV_SCAN;
    endcase
  end

  lcd_edge_det #(.BOTH_EDGES(1'b1)) u_fr_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (frame_i),
    .edge_o (fr_edge)
  );

  lcd_edge_det #(.BOTH_EDGES(1'b0)) u_cl_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (line_clk_i),
    .edge_o (cl_rise)
  );

  lcd_line_ctr #(.ROWS(ROWS)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reload_i    (fr_edge),
    .step_i      (cl_rise && (mode != DRV_SAVE)),
    .duty_full_i (duty_full_i),
    .start_i     (start_line_i),
    .row_o       (row_o),
    .idx_o       (idx)
  );

  lcd_com_drv #(.ROWS(ROWS)) u_com (
    .mode_i (mode),
    .idx_i  (idx),
    .com_o  (com_o)
  );

  lcd_seg_map #(.COLS(COLS)) u_seg (
    .mode_i (mode),
    .adc_i  (adc_i),
    .data_i (row_data_i),
    .seg_o  (seg_o)
  );
endmodule

// File: rtl/lcd_line_scan_chk.sv
module lcd_line_scan_chk #(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned COLS  = 80,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_i,
  input logic             line_clk_i,
  input logic [ROW_W-1:0] start_line_i,
  input logic             disp_on_i,
  input logic             static_i,
  input logic [ROW_W-1:0] row_o,
  input logic [ROWS-1:0]  com_o,
  input logic [COLS-1:0]  seg_o
);
  logic             fr_seen, cl_seen, fr_evt, cl_evt;
  logic [ROW_W-1:0] row_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_seen <= 1'b0;
      cl_seen <= 1'b0;
    end else begin
      fr_seen <= frame_i;
      cl_seen <= line_clk_i;
    end
  end

  assign fr_evt  = frame_i != fr_seen;
  assign cl_evt  = line_clk_i && !cl_seen;
  assign row_inc = row_o + 1'b1;

  assert_fr_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_evt |=> row_o == $past(start_line_i));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_evt && !fr_evt && !(static_i && !disp_on_i))
      |=> (row_o == $past(row_inc)) || (row_o == $past(start_line_i)));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fr_evt && !cl_evt) |=> $stable(row_o));

  assert_save_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fr_evt && static_i && !disp_on_i) |=> $stable(row_o));

  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !static_i |-> $countones(com_o) == 1);

  assert_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!static_i && !disp_on_i) |-> seg_o == '0);

  assert_static_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (static_i && disp_on_i) |-> com_o == '1);

  assert_save_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (static_i && !disp_on_i) |-> (com_o == '0) && (seg_o == '0));
endmodule

bind lcd_line_scan lcd_line_scan_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_i      (frame_i),
  .line_clk_i   (line_clk_i),
  .start_line_i (start_line_i),
  .disp_on_i    (disp_on_i),
  .static_i     (static_i),
  .row_o        (row_o),
  .com_o        (com_o),
  .seg_o        (seg_o)
);

// File: tb/lcd_line_scan_test.sv
`timescale 1ns/1ps
module lcd_line_scan_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic        line_clk_i = 1'b0;
  logic [4:0]  start_line_i = '0;
  logic        duty_full_i = 1'b1;
  logic        adc_i = 1'b1;
  logic        disp_on_i = 1'b1;
  logic        static_i = 1'b0;
  logic [79:0] row_data_i = '0;
  logic [4:0]  row_o;
  logic [31:0] com_o;
  logic [79:0] seg_o;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lcd_line_scan uut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [79:0] mirror(input logic [79:0] d);
    logic [79:0] r;
    for (int n = 0; n < 80; n++) r[n] = d[79-n];
    return r;
  endfunction

  task automatic cl_pulse();
    @(negedge clk_i) line_clk_i = 1'b1;
    @(negedge clk_i) line_clk_i = 1'b0;
  endtask

  task automatic fr_toggle();
    @(negedge clk_i) frame_i = ~frame_i;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 row", 128'(row_o), 128'd0);
    chk("R1 com", 128'(com_o), 128'h1);
  endtask

  task automatic t_reload();
    start_line_i = 5'd7;
    fr_toggle();
    chk("R2 rise row", 128'(row_o), 128'd7);
    cl_pulse(); cl_pulse();
    chk("R3 step row", 128'(row_o), 128'd9);
    chk("R6 com idx2", 128'(com_o), 128'h4);
    start_line_i = 5'd12;
    fr_toggle();
    chk("R2 fall row", 128'(row_o), 128'd12);
    chk("R2 fall com", 128'(com_o), 128'h1);
  endtask

  task automatic t_wrap();
    start_line_i = 5'd30;
    fr_toggle();
    cl_pulse(); cl_pulse();
    chk("R3 wrap row", 128'(row_o), 128'd0);
    chk("R3 wrap com", 128'(com_o), 128'h4);
  endtask

  task automatic t_duty();
    duty_full_i = 1'b1;
    start_line_i = 5'd5;
    fr_toggle();
    for (int i = 0; i < 31; i++) cl_pulse();
    chk("R4 full last row", 128'(row_o), 128'd4);
    chk("R6 full last com", 128'(com_o), 128'h8000_0000);
    start_line_i = 5'd9; // wrap must fetch the new start line
    cl_pulse();
    chk("R4 full wrap row", 128'(row_o), 128'd9);
    chk("R4 full wrap com", 128'(com_o), 128'h1);
    duty_full_i = 1'b0;
    start_line_i = 5'd30;
    fr_toggle();
    for (int i = 0; i < 15; i++) cl_pulse();
    chk("R4 half last row", 128'(row_o), 128'd13);
    chk("R6 half last com", 128'(com_o), 128'h8000);
    cl_pulse();
    chk("R4 half wrap row", 128'(row_o), 128'd30);
    chk("R4 half wrap com", 128'(com_o), 128'h1);
    duty_full_i = 1'b1;
  endtask

  task automatic t_collide();
    start_line_i = 5'd3;
    fr_toggle();
    cl_pulse(); cl_pulse(); cl_pulse();
    chk("R5 pre row", 128'(row_o), 128'd6);
    @(negedge clk_i) begin frame_i = ~frame_i; line_clk_i = 1'b1; end
    @(negedge clk_i) line_clk_i = 1'b0;
    chk("R5 both row", 128'(row_o), 128'd3);
    chk("R5 both com", 128'(com_o), 128'h1);
  endtask

  task automatic t_start_hold();
    start_line_i = 5'd20;
    fr_toggle();
    start_line_i = 5'd1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R11 hold row", 128'(row_o), 128'd20);
    cl_pulse();
    chk("R11 step after", 128'(row_o), 128'd21);
  endtask

  task automatic t_segs();
    logic [79:0] pat = 80'hA5C3_0001_F00D_8000_1234;
    row_data_i = pat;
    adc_i = 1'b1;
    #1 chk("R7 normal", 128'(seg_o), 128'(pat));
    adc_i = 1'b0;
    #1 chk("R7 mirror", 128'(seg_o), 128'(mirror(pat)));
    row_data_i = 80'h1;
    #1 chk("R7 mirror col0", 128'(seg_o), 128'(80'h1) << 79);
    adc_i = 1'b1;
  endtask

  task automatic t_blank();
    logic [4:0] r0;
    row_data_i = '1;
    disp_on_i = 1'b0;
    #1 chk("R8 seg blank", 128'(seg_o), 128'd0);
    r0 = row_o;
    cl_pulse();
    chk("R8 scan runs", 128'(row_o), 128'(r0 + 5'd1));
    chk("R8 com one", 128'($countones(com_o)), 128'd1);
    disp_on_i = 1'b1;
  endtask

  task automatic t_static();
    row_data_i = 80'h0F0F;
    static_i = 1'b1;
    #1 chk("R9 com all", 128'(com_o), {96'd0, 32'hFFFF_FFFF});
    chk("R9 seg data", 128'(seg_o), 128'h0F0F);
    static_i = 1'b0;
  endtask

  task automatic t_save();
    logic [4:0] r0;
    row_data_i = '1;
    r0 = row_o;
    static_i = 1'b1;
    disp_on_i = 1'b0;
    #1 chk("R10 com idle", 128'(com_o), 128'd0);
    chk("R10 seg idle", 128'(seg_o), 128'd0);
    cl_pulse(); cl_pulse();
    static_i = 1'b0;
    disp_on_i = 1'b1;
    #1 chk("R10 cl ignored", 128'(row_o), 128'(r0));
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reload();
    t_wrap();
    t_duty();
    t_collide();
    t_start_hold();
    t_segs();
    t_blank();
    t_static();
    t_save();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule